// File: doc/BRIEF.md
# Dual-Bank Interrupt Controller

This block gathers 32 asynchronous interrupt lines and presents them to a processor through two independent banks: a normal bank and a fast bank. Each bank holds its own enable mask, per-line trigger selection (edge or level), per-line polarity, and a set of pending bits. Each bank drives one request output. Software reads a bank's masked status word and services the lines itself, lowest set bit first. Edge events stay pending until software acknowledges them through a write-one-to-clear register.

Both banks see the same synchronised inputs. A line can therefore be routed to the normal bank, the fast bank, or both, purely through the masks. Register access uses a small request/acknowledge bus controlled by a two-state machine.

The bus machine has two states:
- `BUS_IDLE` takes the transition "accept" to `BUS_RESP` when `bus_req_i` is high. The write, or the read capture, happens on that edge.
- `BUS_RESP` drives `bus_ack_o` for exactly one cycle and takes the unconditional transition "finish" back to `BUS_IDLE`.
- A request seen while in `BUS_RESP` is not accepted.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset every register in both banks reads 0. `irq_req_o`, `fiq_req_o` and `bus_ack_o` are low.
- R2: A request accepted in `BUS_IDLE` is acknowledged on the next cycle, with `bus_rdata_o` valid while `bus_ack_o` is high. Address bit 5 selects the bank (0 normal, 1 fast), and bits 1:0 must be 0. Bits 4:2 select the register: 0 source, 1 mask, 2 acknowledge, 3 trigger, 4 polarity, 5 status (byte offsets 0x00 to 0x14, plus 0x20 for the fast bank). Mask, trigger and polarity read back what was written, and each bank's registers are independent.
- R3: The source register returns the input lines after a two-flop synchroniser. It is the same in both banks.
- R4: A trigger bit of 1 makes the line edge-sensitive. An active edge sets a sticky pending bit that stays set after the input returns to its idle value.
- R5: A polarity bit of 1 makes the line active-low or falling-edge. A polarity bit of 0 makes it active-high or rising-edge.
- R6: A trigger bit of 0 makes the line level-sensitive. Its pending bit follows the active level of the input, and writes to the acknowledge register do not change it.
- R7: Writing 1 to a bit of the acknowledge register clears that edge-pending bit. Bits written as 0 leave their pending bits unchanged.
- R8: The status register equals the pending bits ANDed with the mask (mask 1 = enabled).
- R9: Each bank's request output is a registered OR of that bank's status bits, one cycle behind the status. The two banks' outputs do not affect each other.
- R10: An active edge arriving in the same cycle as an acknowledge of that bit leaves the bit pending.
- R11: `bus_ack_o` is a single-cycle pulse. The following return 0 and have no effect: reads of the acknowledge register, reads of unused register slots (index 6 or 7), and any access with address bits 1:0 not equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | 32 | Asynchronous interrupt lines |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_ack_o | output | 1 | Access completed, read data valid |
| bus_rdata_o | output | 32 | Read data |
| irq_req_o | output | 1 | Normal bank request |
| fiq_req_o | output | 1 | Fast bank request |

## Verification
Some rules are checked by the assertions on every cycle:
- an acknowledged edge bit with no new edge is gone on the next cycle;
- a detected edge is always pending on the next cycle, even when acknowledged at the same time;
- level lines mirror their qualified input;
- the request outputs track the status one cycle later;
- the bus acknowledge is a single pulse.

Other behaviour only the directed scenarios can show:
- the address decode and register readback;
- synchroniser latency on the source register;
- polarity choosing the falling edge;
- masking hiding a pending line;
- ignored accesses, where the bench reads the registers back to confirm nothing changed.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

    typedef enum logic [2:0] {
        SEL_SRC  = 3'd0,
        SEL_MASK = 3'd1,
        SEL_ACK  = 3'd2,
        SEL_TRIG = 3'd3,
        SEL_POL  = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int unsigned DEPTH = STAGES + 1;

    logic [WIDTH-1:0] chain_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) chain_q[s] <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < DEPTH; s++) chain_q[s] <= chain_q[s-1];
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

    assert_prev_trails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> prev_o == $past(sync_o));
endmodule

// File: rtl/intc_bus_fsm.sv
`timescale 1ns/1ps
module intc_bus_fsm
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic ack_o
);
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        accept_o = 1'b0;
        ack_o    = 1'b0;
        unique case (state_q)
            BUS_IDLE: accept_o = req_i;
            BUS_RESP: ack_o    = 1'b1;
            default:  ack_o    = 1'b0;
        endcase
    end

    assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);
    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> ack_o);
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
    import intc_pkg::*;
#(
    parameter int unsigned N_LINES = 32,
    parameter int unsigned IDX_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] sync_now_i,
    input  logic [N_LINES-1:0] sync_prev_i,
    input  logic               wr_en_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [N_LINES-1:0] wdata_i,
    output logic [N_LINES-1:0] rd_data_o,
    output logic               req_o
);
    logic [N_LINES-1:0] mask_q, trig_q, pol_q, pend_q, pend_d;
    logic [N_LINES-1:0] qual, qual_prev, edge_hit, ack_vec, status;
    logic               req_q;

    always_comb begin
        qual      = sync_now_i ^ pol_q;
        qual_prev = sync_prev_i ^ pol_q;
        edge_hit  = trig_q & qual & ~qual_prev;
        ack_vec   = (wr_en_i && idx_i == IDX_W'(SEL_ACK)) ? wdata_i : '0;
        pend_d    = (trig_q & ((pend_q & ~ack_vec) | edge_hit)) | (~trig_q & qual);
        status    = pend_q & mask_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            trig_q <= '0;
            pol_q  <= '0;
            pend_q <= '0;
            req_q  <= 1'b0;
        end else begin
            pend_q <= pend_d;
            req_q  <= |status;
            if (wr_en_i) begin
                if (idx_i == IDX_W'(SEL_MASK)) mask_q <= wdata_i;
                if (idx_i == IDX_W'(SEL_TRIG)) trig_q <= wdata_i;
                if (idx_i == IDX_W'(SEL_POL))  pol_q  <= wdata_i;
            end
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (idx_i == IDX_W'(SEL_SRC))  rd_data_o = sync_now_i;
        if (idx_i == IDX_W'(SEL_MASK)) rd_data_o = mask_q;
        if (idx_i == IDX_W'(SEL_TRIG)) rd_data_o = trig_q;
        if (idx_i == IDX_W'(SEL_POL))  rd_data_o = pol_q;
        if (idx_i == IDX_W'(SEL_STAT)) rd_data_o = status;
    end

    assign req_o = req_q;

    assert_ack_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (pend_q & $past(trig_q & ack_vec & ~edge_hit)) == '0);
    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> (pend_q & $past(edge_hit)) == $past(edge_hit));
    assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1 |=> ((pend_q ^ $past(qual)) & $past(~trig_q)) == '0);
    assert_req_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |=> !req_o);
    assert_req_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |=> req_o);
endmodule

// File: rtl/dual_bank_intc.sv
`timescale 1ns/1ps
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int unsigned N_LINES     = 32,
    parameter int unsigned ADDR_W      = 6,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines_i,
    input  logic               bus_req_i,
    input  logic               bus_we_i,
    input  logic [ADDR_W-1:0]  bus_addr_i,
    input  logic [N_LINES-1:0] bus_wdata_i,
    output logic               bus_ack_o,
    output logic [N_LINES-1:0] bus_rdata_o,
    output logic               irq_req_o,
    output logic               fiq_req_o
);
    localparam int unsigned BANK_BIT = ADDR_W - 1;
    localparam int unsigned IDX_W    = ADDR_W - 3;

    logic [N_LINES-1:0] sync_now, sync_prev;
    logic               accept;
    logic               aligned;
    logic [IDX_W-1:0]   sel_idx;
    logic [N_LINES-1:0] bank_rd [NUM_BANKS];
    logic [NUM_BANKS-1:0] bank_req;
    logic [N_LINES-1:0] rdata_q;

    assign aligned = (bus_addr_i[1:0] == 2'b00);
    assign sel_idx = bus_addr_i[BANK_BIT-1:2];

    intc_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .async_i(irq_lines_i),
        .sync_o(sync_now), .prev_o(sync_prev)
    );

    intc_bus_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .req_i(bus_req_i),
        .accept_o(accept), .ack_o(bus_ack_o)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic wr_en;
        assign wr_en = accept && bus_we_i && aligned && (bus_addr_i[BANK_BIT] == 1'(b));
        intc_bank #(.N_LINES(N_LINES), .IDX_W(IDX_W)) bank_i (
            .clk(clk), .rst_n(rst_n),
            .sync_now_i(sync_now), .sync_prev_i(sync_prev),
            .wr_en_i(wr_en), .idx_i(sel_idx), .wdata_i(bus_wdata_i),
            .rd_data_o(bank_rd[b]), .req_o(bank_req[b])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (accept) begin
            rdata_q <= (!bus_we_i && aligned) ? bank_rd[bus_addr_i[BANK_BIT]] : '0;
        end
    end

    assign bus_rdata_o = rdata_q;
    assign irq_req_o   = bank_req[0];
    assign fiq_req_o   = bank_req[1];

    assert_misaligned_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !aligned) |=> bus_rdata_o == '0);
endmodule

// File: tb/dual_bank_intc_tb_top.sv
`timescale 1ns/1ps
module dual_bank_intc_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lines = '0;
    logic        req = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, irq, fiq;
    logic [31:0] rdata;
    int          checks = 0, fails = 0;
    logic        last_ack;
    logic        done = 1'b0;

    localparam logic [5:0] N_SRC = 6'h00, N_MSK = 6'h04, N_ACK = 6'h08,
                           N_TRG = 6'h0C, N_POL = 6'h10, N_STA = 6'h14;
    localparam logic [5:0] FAST = 6'h20;

    always #2.5 clk = ~clk;

    dual_bank_intc dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines_i(lines),
        .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_ack_o(ack), .bus_rdata_o(rdata), .irq_req_o(irq), .fiq_req_o(fiq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk); req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
        @(posedge clk);
        @(negedge clk); req = 1'b0; d = rdata; last_ack = ack;
    endtask

    task automatic rd_chk(input string tag, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 fiq", {31'd0, fiq}, 32'd0);
        chk("R1 ack", {31'd0, ack}, 32'd0);
        for (int b = 0; b < 2; b++)
            for (int r = 0; r < 6; r++)
                rd_chk("R1 reg", 6'((b * 32) + (r * 4)), 32'd0);
    endtask

    task automatic t_config;
        wr(N_MSK, 32'h1234_5678);
        wr(FAST | N_TRG, 32'hCAFE_0001);
        wr(FAST | N_POL, 32'h0F0F_0000);
        rd_chk("R2 mask readback", N_MSK, 32'h1234_5678);
        chk("R2 ack with data", {31'd0, last_ack}, 32'd1);
        rd_chk("R2 trig readback", FAST | N_TRG, 32'hCAFE_0001);
        rd_chk("R2 pol readback", FAST | N_POL, 32'h0F0F_0000);
        rd_chk("R2 bank independent", N_TRG, 32'd0);
        rd_chk("R2 fast mask untouched", FAST | N_MSK, 32'd0);
        wr(N_MSK, 0); wr(FAST | N_TRG, 0); wr(FAST | N_POL, 0);
    endtask

    task automatic t_source;
        lines = 32'hA5A5_0F0F;
        settle(3);
        rd_chk("R3 source normal", N_SRC, 32'hA5A5_0F0F);
        rd_chk("R3 source fast", FAST | N_SRC, 32'hA5A5_0F0F);
        lines = '0;
        settle(3);
    endtask

    task automatic t_edge_rise;
        logic [31:0] v;
        wr(N_TRG, 32'h8); wr(N_POL, 0); wr(N_MSK, 32'h8); wr(N_ACK, 32'hFFFF_FFFF);
        lines[3] = 1'b1; settle(5);
        chk("R9 irq on edge", {31'd0, irq}, 32'd1);
        chk("R9 fiq independent", {31'd0, fiq}, 32'd0);
        rd_chk("R4 pending on rise", N_STA, 32'h8);
        lines[3] = 1'b0; settle(5);
        rd_chk("R4 sticky after release", N_STA, 32'h8);
        wr(N_ACK, 32'hFFFF_FFF7);
        rd_chk("R7 zero bits no effect", N_STA, 32'h8);
        wr(N_ACK, 32'h8);
        rd(N_STA, v);
        chk("R7 ack clears", v, 32'd0);
        settle(1);
        chk("R9 irq drops", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_edge_fall;
        wr(FAST | N_TRG, 32'h20); wr(FAST | N_POL, 32'h20); wr(FAST | N_MSK, 32'h20);
        wr(FAST | N_ACK, 32'hFFFF_FFFF);
        lines[5] = 1'b1; settle(5);
        rd_chk("R5 rise ignored when falling", FAST | N_STA, 32'd0);
        lines[5] = 1'b0; settle(5);
        rd_chk("R5 falling edge pends", FAST | N_STA, 32'h20);
        chk("R5 fiq raised", {31'd0, fiq}, 32'd1);
        wr(FAST | N_ACK, 32'h20);
        wr(FAST | N_TRG, 0); wr(FAST | N_POL, 0); wr(FAST | N_MSK, 0);
    endtask

    task automatic t_level;
        wr(FAST | N_TRG, 0); wr(FAST | N_POL, 32'h200); wr(FAST | N_MSK, 32'h280);
        settle(2);
        rd_chk("R6 active-low level", FAST | N_STA, 32'h200);
        lines[7] = 1'b1; settle(5);
        rd_chk("R6 active-high level", FAST | N_STA, 32'h280);
        wr(FAST | N_ACK, 32'h280);
        rd_chk("R6 ack ignored on level", FAST | N_STA, 32'h280);
        lines[7] = 1'b0; lines[9] = 1'b1; settle(5);
        rd_chk("R6 level follows input", FAST | N_STA, 32'd0);
        settle(1);
        chk("R9 fiq low", {31'd0, fiq}, 32'd0);
        lines = '0;
        wr(FAST | N_POL, 0); wr(FAST | N_MSK, 0);
    endtask

    task automatic t_mask;
        wr(N_TRG, 32'h1000); wr(N_POL, 0); wr(N_MSK, 0); wr(N_ACK, 32'hFFFF_FFFF);
        lines[12] = 1'b1; settle(5); lines[12] = 1'b0; settle(5);
        rd_chk("R8 masked hides pending", N_STA, 32'd0);
        chk("R8 masked irq low", {31'd0, irq}, 32'd0);
        wr(N_MSK, 32'h1000);
        rd_chk("R8 unmask reveals", N_STA, 32'h1000);
        chk("R8 irq after unmask", {31'd0, irq}, 32'd1);
        wr(N_MSK, 0); wr(N_ACK, 32'h1000);
    endtask

    task automatic t_same_cycle;
        wr(N_TRG, 32'h14); wr(N_POL, 0); wr(N_MSK, 32'h14); wr(N_ACK, 32'hFFFF_FFFF);
        lines[2] = 1'b1; lines[4] = 1'b1; settle(5);
        lines = '0; settle(5);
        rd_chk("R10 both pending", N_STA, 32'h14);
        @(negedge clk); lines[2] = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); req = 1'b1; we = 1'b1; addr = N_ACK; wdata = 32'h14;
        @(posedge clk);
        @(negedge clk); req = 1'b0; we = 1'b0;
        rd_chk("R10 edge beats ack", N_STA, 32'h4);
        lines = '0; settle(3);
        wr(N_ACK, 32'hFFFF_FFFF); wr(N_MSK, 0); wr(N_TRG, 0);
    endtask

    task automatic t_unmapped;
        wr(N_MSK, 32'h0000_00F0);
        rd_chk("R11 slot 6 zero", 6'h18, 32'd0);
        rd_chk("R11 slot 7 fast zero", 6'h3C, 32'd0);
        rd_chk("R11 misaligned read zero", 6'h05, 32'd0);
        rd_chk("R11 ack reg reads zero", FAST | N_ACK, 32'd0);
        chk("R11 ack high in response", {31'd0, last_ack}, 32'd1);
        @(negedge clk);
        chk("R11 ack single cycle", {31'd0, ack}, 32'd0);
        wr(6'h05, 32'hFFFF_FFFF);
        rd_chk("R11 misaligned write ignored", N_MSK, 32'h0000_00F0);
        wr(N_MSK, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_config();
        t_source();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_mask();
        t_same_cycle();
        t_unmapped();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
        end
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule